// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a small 32-bit processor that finishes every instruction in one clock. On each cycle it takes the instruction addressed by the program counter from a word-indexed instruction store and decodes it into one of eight operation kinds: load upper immediate, add immediate, register add, register subtract, word load, word store, branch on equal and absolute jump. In the same cycle it reads two operands from a 32-entry register file, forms a result or an address in one adder, and chooses the next program counter. Register 0 always reads as zero.

Clock and synchronous reset are the only inputs. The instruction store is filled from outside the block through its storage array while reset is held. The data store starts empty and is filled by the program itself. Three groups of outputs show what the core does: the current program counter, a register write strobe with its index and value, and a store strobe with its byte address and data. Each strobe describes the instruction executing in that cycle, and the write it shows takes effect on the next rising edge.

The core has no pipeline and no traps. An encoding outside the subset runs as a no-operation and falls through to the next instruction.

Top module: `sc_core`

## Requirements
- R1: Opcode 0x0F (load upper immediate) writes {imm16, 16'h0000} to register rt (instruction bits 20:16).
- R2: Opcode 0x09 (add immediate) writes rs plus the sign-extended imm16 to rt. rs is in instruction bits 25:21.
- R3: Opcode 0x00 with shamt (bits 10:6) zero writes rd (bits 15:11). Funct 0x20 writes rs+rt and funct 0x23 writes rs−rt. Both wrap modulo 2^32 and never trap.
- R4: Opcode 0x2B (store word) writes rt to data word index (rs+sext(imm16))>>2 on the rising edge. In the same cycle it raises st_valid with that byte address and value.
- R5: Opcode 0x23 (load word) writes data word (rs+sext(imm16))>>2, read combinationally, to rt.
- R6: Opcode 0x04 (branch on equal) sets the next PC to PC+4+(sext(imm16)<<2) when rs equals rt, and to PC+4 otherwise.
- R7: Opcode 0x02 (jump) sets the next PC to {PCplus4[31:27+1], target26, 2'b00}, where PCplus4[31:28] supplies the top 4 bits. Instruction fetch uses only the low word-address bits of the PC, so 0x0040000C fetches word 3.
- R8: Register 0 reads as zero. A write aimed at it is dropped and does not raise wb_valid.
- R9: Instructions passed over by a taken branch or a jump change no register. Any encoding outside R1–R7 (for example opcode 0x0D, or funct 0x21) writes nothing and advances the PC by 4.
- R10: While rst is high, the PC is held at 0 on each rising edge, wb_valid and st_valid stay low, and every register is cleared.
- R11: Every instruction other than a taken branch or a jump advances the PC by exactly 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| pc_o | output | 32 | Byte address of the executing instruction |
| wb_valid_o | output | 1 | A register write to a nonzero index commits at the next edge |
| wb_idx_o | output | 5 | Destination register index |
| wb_value_o | output | 32 | Value being written |
| st_valid_o | output | 1 | A data-store write commits at the next edge |
| st_addr_o | output | 32 | Byte address of the store |
| st_value_o | output | 32 | Word being stored |

## Verification
The ports show every change of architectural state in the same cycle it is committed. A wrong decode, a wrong operand or a corrupted register therefore shows up on wb_value_o or st_value_o no later than the first instruction that reads the bad value. A wrong next-PC shows up one cycle later: the write sequence gains an extra event, loses one, or reorders. The scoreboard compares the exact order of write and store events, so a write from a skipped instruction, or from an encoding that should be a no-operation, counts as an unexpected event. Loads that follow stores bring the state of the data store out to the ports.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN   = 32;
    localparam int REG_AW = 5;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_JUMP  = 6'h02;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_ADDIU = 6'h09;
    localparam logic [5:0] OPC_LUI   = 6'h0F;
    localparam logic [5:0] OPC_LW    = 6'h23;
    localparam logic [5:0] OPC_SW    = 6'h2B;

    localparam logic [5:0] FN_ADD  = 6'h20;
    localparam logic [5:0] FN_SUBU = 6'h23;

    typedef enum logic [3:0] {
        K_NOP,
        K_LUI,
        K_ADDIU,
        K_ADD,
        K_SUBU,
        K_LW,
        K_SW,
        K_BEQ,
        K_J
    } op_kind_e;

    typedef struct packed {
        op_kind_e          kind;
        logic [REG_AW-1:0] rs;
        logic [REG_AW-1:0] rt;
        logic [REG_AW-1:0] rd;
        logic [15:0]       imm16;
        logic [25:0]       target26;
    } decoded_t;

endpackage

// File: rtl/sc_imem.sv
module sc_imem #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [31:0]      instr_o
);

    logic [31:0] rom [DEPTH];

    // Power-up contents are all zero, which decodes as a no-operation.
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            rom[i] = '0;
        end
    end

    assign instr_o = rom[idx_i];

endmodule

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [31:0] instr_i,
    output decoded_t    dec_o
);

    logic [5:0] opcode;
    logic [5:0] funct;
    logic [4:0] shamt;

    assign opcode = instr_i[31:26];
    assign funct  = instr_i[5:0];
    assign shamt  = instr_i[10:6];

    always_comb begin
        dec_o.rs       = instr_i[25:21];
        dec_o.rt       = instr_i[20:16];
        dec_o.rd       = instr_i[15:11];
        dec_o.imm16    = instr_i[15:0];
        dec_o.target26 = instr_i[25:0];
        dec_o.kind     = K_NOP;
        unique case (opcode)
            OPC_RTYPE: begin
                if (shamt == 5'd0) begin
                    unique case (funct)
                        FN_ADD:  dec_o.kind = K_ADD;
                        FN_SUBU: dec_o.kind = K_SUBU;
                        default: dec_o.kind = K_NOP;
                    endcase
                end
            end
            OPC_JUMP:  dec_o.kind = K_J;
            OPC_BEQ:   dec_o.kind = K_BEQ;
            OPC_ADDIU: dec_o.kind = K_ADDIU;
            OPC_LUI:   dec_o.kind = K_LUI;
            OPC_LW:    dec_o.kind = K_LW;
            OPC_SW:    dec_o.kind = K_SW;
            default:   dec_o.kind = K_NOP;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [AW-1:0] ra1_i,
    output logic [W-1:0]  rd1_o,
    input  logic [AW-1:0] ra2_i,
    output logic [W-1:0]  rd2_o
);

    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (we_i && (waddr_i != '0)) begin
            regs[waddr_i] <= wdata_i;
        end
    end

    assign rd1_o = (ra1_i == '0) ? '0 : regs[ra1_i];
    assign rd2_o = (ra2_i == '0) ? '0 : regs[ra2_i];

endmodule

// File: rtl/sc_alu.sv
module sc_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] y_o
);

    // One adder serves both operations; subtraction is a + ~b + 1.
    logic [W-1:0] b_eff;

    assign b_eff = sub_i ? ~b_i : b_i;
    assign y_o   = a_i + b_eff + {{(W-1){1'b0}}, sub_i};

endmodule

// File: rtl/sc_dmem.sv
module sc_dmem #(
    parameter int DEPTH = 64,
    parameter int W     = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [W-1:0]     wdata_i,
    output logic [W-1:0]     rdata_o
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[idx_i] <= wdata_i;
        end
    end

    assign rdata_o = mem[idx_i];

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_DEPTH = 64,
    parameter int DMEM_DEPTH = 64,
    parameter int NREG       = 32
) (
    input  logic              clk,
    input  logic              rst,
    output logic [31:0]       pc_o,
    output logic              wb_valid_o,
    output logic [REG_AW-1:0] wb_idx_o,
    output logic [31:0]       wb_value_o,
    output logic              st_valid_o,
    output logic [31:0]       st_addr_o,
    output logic [31:0]       st_value_o
);

    localparam int IIDX_W = $clog2(IMEM_DEPTH);
    localparam int DIDX_W = $clog2(DMEM_DEPTH);

    logic [31:0] pc_q;
    logic [31:0] pc_next;
    logic [31:0] pc_plus4;
    logic [31:0] instr;
    decoded_t    dec;
    op_kind_e    kind;
    logic [15:0] imm16;
    logic [31:0] imm_sext;
    logic [31:0] rs_val;
    logic [31:0] rt_val;
    logic [31:0] alu_b;
    logic        alu_sub;
    logic [31:0] alu_y;
    logic [31:0] load_data;
    logic        wr_en;
    logic [REG_AW-1:0] wr_dst;
    logic [31:0] wr_val;
    logic        mem_we;

    // ---------------- fetch ----------------
    sc_imem #(.DEPTH(IMEM_DEPTH)) u_imem (
        .idx_i   (pc_q[IIDX_W+1:2]),
        .instr_o (instr)
    );

    // ---------------- decode ----------------
    sc_decode u_decode (
        .instr_i (instr),
        .dec_o   (dec)
    );

    assign kind     = dec.kind;
    assign imm16    = dec.imm16;
    assign imm_sext = {{16{imm16[15]}}, imm16};

    // ---------------- operands ----------------
    sc_regfile #(.NREG(NREG), .W(XLEN)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we_i    (wb_valid_o),
        .waddr_i (wr_dst),
        .wdata_i (wr_val),
        .ra1_i   (dec.rs),
        .rd1_o   (rs_val),
        .ra2_i   (dec.rt),
        .rd2_o   (rt_val)
    );

    // ---------------- execute ----------------
    always_comb begin
        alu_b   = imm_sext;
        alu_sub = 1'b0;
        unique case (kind)
            K_ADD:   alu_b = rt_val;
            K_SUBU: begin
                alu_b   = rt_val;
                alu_sub = 1'b1;
            end
            default: alu_b = imm_sext;
        endcase
    end

    sc_alu #(.W(XLEN)) u_alu (
        .a_i   (rs_val),
        .b_i   (alu_b),
        .sub_i (alu_sub),
        .y_o   (alu_y)
    );

    // ---------------- data store ----------------
    sc_dmem #(.DEPTH(DMEM_DEPTH), .W(XLEN)) u_dmem (
        .clk     (clk),
        .we_i    (st_valid_o),
        .idx_i   (alu_y[DIDX_W+1:2]),
        .wdata_i (rt_val),
        .rdata_o (load_data)
    );

    // ---------------- write-back select ----------------
    always_comb begin
        wr_en  = 1'b0;
        wr_dst = dec.rt;
        wr_val = alu_y;
        mem_we = 1'b0;
        unique case (kind)
            K_LUI: begin
                wr_en  = 1'b1;
                wr_val = {imm16, 16'h0000};
            end
            K_ADDIU: wr_en = 1'b1;
            K_ADD, K_SUBU: begin
                wr_en  = 1'b1;
                wr_dst = dec.rd;
            end
            K_LW: begin
                wr_en  = 1'b1;
                wr_val = load_data;
            end
            K_SW:  mem_we = 1'b1;
            K_BEQ, K_J, K_NOP: begin
                wr_en  = 1'b0;
                mem_we = 1'b0;
            end
            default: begin
                wr_en  = 1'b0;
                mem_we = 1'b0;
            end
        endcase
    end

    assign wb_valid_o = wr_en && !rst && (wr_dst != '0);
    assign wb_idx_o   = wr_dst;
    assign wb_value_o = wr_val;
    assign st_valid_o = mem_we && !rst;
    assign st_addr_o  = alu_y;
    assign st_value_o = rt_val;

    // ---------------- next PC ----------------
    assign pc_plus4 = pc_q + 32'd4;

    always_comb begin
        pc_next = pc_plus4;
        unique case (kind)
            K_BEQ: begin
                if (rs_val == rt_val) begin
                    pc_next = pc_plus4 + {imm_sext[29:0], 2'b00};
                end
            end
            K_J:     pc_next = {pc_plus4[31:28], dec.target26, 2'b00};
            default: pc_next = pc_plus4;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    assign pc_o = pc_q;

endmodule

// File: rtl/sc_core_checker.sv
module sc_core_checker
    import sc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc_o,
    input logic        wb_valid_o,
    input logic [4:0]  wb_idx_o,
    input logic [31:0] wb_value_o,
    input logic        st_valid_o,
    input op_kind_e    kind,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic [15:0] imm16
);

    // R8: a write to register 0 never surfaces as a commit
    a_r8_no_zero_write: assert property (@(posedge clk) disable iff (rst)
        wb_valid_o |-> (wb_idx_o != 5'd0));

    // R10: reset pulls the PC back to zero
    a_r10_reset_pc: assert property (@(posedge clk)
        rst |=> (pc_o == 32'd0));

    // R10: no commit strobes while reset is high
    a_r10_quiet_reset: assert property (@(posedge clk)
        rst |-> (!wb_valid_o && !st_valid_o));

    // R11: non-control instructions step the PC by 4
    a_r11_seq_pc: assert property (@(posedge clk) disable iff (rst)
        (kind != K_BEQ && kind != K_J) |=> (pc_o == $past(pc_o) + 32'd4));

    // R6: taken branch lands on PC+4 plus scaled offset
    a_r6_beq_taken: assert property (@(posedge clk) disable iff (rst)
        (kind == K_BEQ && rs_val == rt_val) |=>
        (pc_o == $past(pc_o) + 32'd4 + {{14{$past(imm16[15])}}, $past(imm16), 2'b00}));

    // R6: untaken branch falls through
    a_r6_beq_fall: assert property (@(posedge clk) disable iff (rst)
        (kind == K_BEQ && rs_val != rt_val) |=> (pc_o == $past(pc_o) + 32'd4));

    // R1: the low half of an upper-immediate result is zero
    a_r1_lui_low: assert property (@(posedge clk) disable iff (rst)
        (wb_valid_o && kind == K_LUI) |-> (wb_value_o[15:0] == 16'h0000));

    // R4: one instruction never writes both a register and memory
    a_r4_one_target: assert property (@(posedge clk) disable iff (rst)
        !(wb_valid_o && st_valid_o));

    // R11: the PC stays word aligned
    a_r11_aligned: assert property (@(posedge clk) disable iff (rst)
        pc_o[1:0] == 2'b00);

endmodule

bind sc_core sc_core_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .pc_o       (pc_o),
    .wb_valid_o (wb_valid_o),
    .wb_idx_o   (wb_idx_o),
    .wb_value_o (wb_value_o),
    .st_valid_o (st_valid_o),
    .kind       (kind),
    .rs_val     (rs_val),
    .rt_val     (rt_val),
    .imm16      (imm16)
);

// File: tb/sc_core_bench.sv
module sc_core_bench;

    localparam int IMEM_DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_o;
    logic        wb_valid_o;
    logic [4:0]  wb_idx_o;
    logic [31:0] wb_value_o;
    logic        st_valid_o;
    logic [31:0] st_addr_o;
    logic [31:0] st_value_o;

    int checks   = 0;
    int failures = 0;

    always #2 clk = ~clk;

    sc_core #(.IMEM_DEPTH(IMEM_DEPTH)) u_sc_core (
        .clk        (clk),
        .rst        (rst),
        .pc_o       (pc_o),
        .wb_valid_o (wb_valid_o),
        .wb_idx_o   (wb_idx_o),
        .wb_value_o (wb_value_o),
        .st_valid_o (st_valid_o),
        .st_addr_o  (st_addr_o),
        .st_value_o (st_value_o)
    );

    typedef struct {
        bit          is_store;
        int          idx;
        logic [31:0] addr;
        logic [31:0] val;
        string       tag;
    } exp_item_t;

    exp_item_t sb[$];

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, rs[4:0], rt[4:0], imm};
    endfunction

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_j(logic [25:0] t);
        return {6'h02, t};
    endfunction

    task automatic exp_w(int idx, logic [31:0] val, string tag);
        exp_item_t it;
        it.is_store = 1'b0; it.idx = idx; it.addr = '0; it.val = val; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic exp_s(logic [31:0] addr, logic [31:0] val, string tag);
        exp_item_t it;
        it.is_store = 1'b1; it.idx = 0; it.addr = addr; it.val = val; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic put(int idx, logic [31:0] w);
        u_sc_core.u_imem.rom[idx] = w;
    endtask

    task automatic clear_rom();
        for (int i = 0; i < IMEM_DEPTH; i++) put(i, 32'h0);
    endtask

    // Monitor: compare each commit event with the scoreboard head
    always @(negedge clk) begin
        if (!rst && (wb_valid_o || st_valid_o)) begin
            if (sb.size() == 0) begin
                check(1'b0, "R9 unexpected commit", wb_valid_o ? wb_value_o : st_value_o, 32'h0);
            end else begin
                exp_item_t e;
                e = sb.pop_front();
                if (e.is_store) begin
                    check(st_valid_o && st_addr_o == e.addr, {e.tag, " store addr"}, st_addr_o, e.addr);
                    check(st_valid_o && st_value_o == e.val, {e.tag, " store data"}, st_value_o, e.val);
                end else begin
                    check(wb_valid_o && wb_idx_o == e.idx[4:0], {e.tag, " wb index"},
                          {27'd0, wb_idx_o}, e.idx);
                    check(wb_valid_o && wb_value_o == e.val, {e.tag, " wb value"}, wb_value_o, e.val);
                end
            end
        end
    end

    task automatic run_prog(int cycles);
        @(negedge clk);
        check(pc_o == 32'h0, "R10 reset pc", pc_o, 32'h0);
        check(!wb_valid_o && !st_valid_o, "R10 quiet in reset",
              {30'd0, wb_valid_o, st_valid_o}, 32'h0);
        rst = 1'b0;
        repeat (cycles) @(negedge clk);
        check(sb.size() == 0, "R9 missing commits", sb.size(), 32'h0);
        sb.delete();
        rst = 1'b1;
        @(posedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R10 watchdog expired", 32'h0, 32'h1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1;
        @(posedge clk);

        // Program A: arithmetic (R1, R2, R3)
        clear_rom();
        put(0, 32'h3c010001);
        put(1, 32'h3c020002);
        put(2, 32'h00221820);
        put(3, 32'h00412023);
        put(4, enc_i(6'h09, 1, 5, 16'd1024));
        put(5, enc_i(6'h09, 0, 6, 16'hFFFF));
        put(6, enc_r(1, 2, 7, 6'h23));
        exp_w(1, 32'h00010000, "R1");
        exp_w(2, 32'h00020000, "R1");
        exp_w(3, 32'h00030000, "R3");
        exp_w(4, 32'h00010000, "R3");
        exp_w(5, 32'h00010400, "R2");
        exp_w(6, 32'hFFFFFFFF, "R2");
        exp_w(7, 32'hFFFF0000, "R3");
        run_prog(16);

        // Program B: stores then loads (R4, R5)
        clear_rom();
        put(0, enc_i(6'h09, 0, 1, 16'd1));
        put(1, enc_i(6'h2B, 0, 1, 16'd0));
        put(2, enc_i(6'h09, 0, 2, 16'd15));
        put(3, enc_i(6'h2B, 0, 2, 16'd4));
        put(4, enc_i(6'h09, 0, 3, 16'd9));
        put(5, enc_i(6'h2B, 0, 3, 16'd8));
        put(6, enc_i(6'h23, 0, 4, 16'd4));
        put(7, enc_i(6'h23, 0, 5, 16'd0));
        put(8, enc_i(6'h09, 0, 8, 16'd4));
        put(9, enc_i(6'h23, 8, 6, 16'd4));
        put(10, enc_i(6'h2B, 8, 6, 16'hFFFC));
        put(11, enc_i(6'h23, 0, 7, 16'd0));
        exp_w(1, 32'd1, "R2");
        exp_s(32'd0, 32'd1, "R4");
        exp_w(2, 32'd15, "R2");
        exp_s(32'd4, 32'd15, "R4");
        exp_w(3, 32'd9, "R2");
        exp_s(32'd8, 32'd9, "R4");
        exp_w(4, 32'd15, "R5");
        exp_w(5, 32'd1, "R5");
        exp_w(8, 32'd4, "R2");
        exp_w(6, 32'd9, "R5");
        exp_s(32'd0, 32'd9, "R4");
        exp_w(7, 32'd9, "R5");
        run_prog(18);

        // Program C: branches (R6, R9)
        clear_rom();
        put(0, 32'h240b0009);
        put(1, 32'h240a0009);
        put(2, 32'h116a0002);
        put(3, 32'h3c010001);
        put(4, 32'h3c020002);
        put(5, 32'h3c030003);
        put(6, 32'h3c040004);
        put(7, enc_i(6'h09, 0, 12, 16'd5));
        put(8, enc_i(6'h04, 12, 11, 16'd1));
        put(9, enc_i(6'h0F, 0, 13, 16'h000D));
        put(10, enc_i(6'h04, 0, 0, 16'd1));
        put(11, enc_i(6'h0F, 0, 14, 16'h000E));
        put(12, enc_i(6'h0F, 0, 15, 16'h000F));
        exp_w(11, 32'd9, "R2");
        exp_w(10, 32'd9, "R2");
        exp_w(3, 32'h00030000, "R6 taken");
        exp_w(4, 32'h00040000, "R6 taken");
        exp_w(12, 32'd5, "R2");
        exp_w(13, 32'h000D0000, "R6 not taken");
        exp_w(15, 32'h000F0000, "R6 zero compare");
        run_prog(18);

        // Program D: jumps with text-base aliasing (R7, R9, R10 cleared regs)
        clear_rom();
        put(0, 32'h08100003);
        put(1, 32'h3c010001);
        put(2, 32'h3c020002);
        put(3, 32'h3c030003);
        put(4, 32'h3c040004);
        put(5, enc_j(26'h0100007));
        put(6, enc_i(6'h0F, 0, 5, 16'h0005));
        put(7, enc_i(6'h0F, 0, 6, 16'h0006));
        put(8, enc_r(1, 2, 9, 6'h20));
        exp_w(3, 32'h00030000, "R7");
        exp_w(4, 32'h00040000, "R7");
        exp_w(6, 32'h00060000, "R7 second jump");
        exp_w(9, 32'h00000000, "R10 regs cleared");
        run_prog(14);

        // Program E: register zero, wrap, illegal encodings (R8, R3, R9)
        clear_rom();
        put(0, enc_i(6'h09, 0, 0, 16'd5));
        put(1, enc_i(6'h09, 0, 1, 16'd7));
        put(2, enc_i(6'h0D, 0, 2, 16'd3));
        put(3, enc_i(6'h0F, 0, 3, 16'h8000));
        put(4, enc_r(3, 3, 4, 6'h20));
        put(5, enc_r(0, 1, 5, 6'h20));
        put(6, enc_r(1, 1, 6, 6'h21));
        put(7, enc_r(1, 1, 0, 6'h20));
        put(8, enc_r(0, 1, 7, 6'h23));
        exp_w(1, 32'd7, "R8");
        exp_w(3, 32'h80000000, "R1");
        exp_w(4, 32'h00000000, "R3 wrap");
        exp_w(5, 32'd7, "R8 reads zero");
        exp_w(7, 32'hFFFFFFF9, "R3");
        run_prog(14);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule